// File: doc/BRIEF.md
# Splittable 64-bit Timer with Watchdog

This block is a programmable counter peripheral with three modes of operation. In chained mode a low and a high 32-bit counter form one 64-bit timer. In split mode the same two counters run as independent 32-bit timers, each with its own period, enable, count source, one-shot option and pin pair. In watchdog mode the 64-bit count runs down toward zero and software must service it with a two-key write sequence.

Each counter advances on every clock or on rising edges of its own external pin, depending on its count source. The external pin passes through a two-flop synchronizer and an edge detector before it reaches the counter. When a counter reaches its programmed period it returns to zero, emits a single-cycle interrupt pulse and drives its output pin, either as a fixed-width pulse or as a level that toggles. Software reaches all registers through a synchronous write port and a combinational read port.

Top module: `tmr64_split`

## Requirements
- R1: After reset every register reads 0 and all outputs are low. Register addresses on addr_i are: 0 control, 1 low period, 2 high period, 3 low count, 4 high count, 5 service key. The control register holds mode in bits [1:0] (0 chained, 1 split, 2 watchdog; a write of 3 leaves the mode unchanged). Bit 2 is the low enable, bit 3 selects the low external source, bit 4 is the low one-shot and bit 5 is the low toggle. Bits [9:6] hold the same four fields for the high half.
- R2: In split mode with its source on the clock, a counter whose period is P gives an interrupt pulse once every P+1 cycles. The low and high halves run independently, each with its own period.
- R3: When a half's external-source bit is set, its count rises by one for each rising edge on its own pin, provided the pin stays high for at least 12 cycles and low for at least 12 cycles. Clock cycles and the other half's pin do not change that count.
- R4: In chained mode the low counter carries into the high counter, the period match compares all 64 bits, and the match drives irq_lo_o and tout_lo_o. In this mode irq_hi_o stays low.
- R5: In split mode the low counter wrapping through its period has no effect on the high count.
- R6: When a half's one-shot bit is set, a period match clears that half's enable bit, so the half gives exactly one event.
- R7: When the toggle bit is clear, the output pin goes high in the same cycle as the interrupt pulse and stays high for exactly 12 cycles.
- R8: When the toggle bit is set, the output pin changes level at every period match.
- R9: Writing mode 2 loads the 64-bit count from the 64-bit period. After that the count decreases by one on every clock.
- R10: The count is reloaded from the period only by a write of 0x5EED to the service key followed by a write of 0xC0DE. Any other order or value does not reload it. Writes to the count registers are ignored in watchdog mode.
- R11: Once watchdog mode is entered, control writes cannot change the mode until reset.
- R12: When the watchdog count reaches zero, wd_o rises and stays high until reset. Service writes after that point do not reload the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| tin_lo_i | input | 1 | External count input, low half |
| tin_hi_i | input | 1 | External count input, high half |
| tout_lo_o | output | 1 | Output pin, low half |
| tout_hi_o | output | 1 | Output pin, high half |
| irq_lo_o | output | 1 | Period-match event, low half or chained timer |
| irq_hi_o | output | 1 | Period-match event, high half |
| wd_o | output | 1 | Watchdog expiry, sticky |

## Verification
The split-mode periods are swept over pairs whose sum is fixed, so the two halves always have different periods. The interval of each half must match only its own period, which would expose any crosstalk between the halves. External counting drives a different number of pin pulses on each half, which separates edge counting from clock counting and from the other pin. Near-wrap preloads in chained and split mode show whether the carry is present or absent. In watchdog mode the correct key order, the reversed order and a wrong key each give a different trend in the readback count, and the expired state is probed with a service that arrives too late.

// File: rtl/tmr64_pkg.sv
package tmr64_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_PRD_LO = 3'd1,
    A_PRD_HI = 3'd2,
    A_CNT_LO = 3'd3,
    A_CNT_HI = 3'd4,
    A_WD_KEY = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    M_CHAIN = 2'd0,
    M_SPLIT = 2'd1,
    M_WDOG  = 2'd2
  } tmr_mode_e;

  typedef struct packed {
    logic toggle;
    logic oneshot;
    logic ext;
    logic en;
  } half_cfg_t;
endpackage

// File: rtl/tmr_in_sync.sv
module tmr_in_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/tmr_pin_out.sv
module tmr_pin_out #(
  parameter int unsigned PULSE_LEN = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic toggle_i,
  output logic pin_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      lvl_q  <= 1'b0;
    end else if (hit_i) begin
      left_q <= PW'(PULSE_LEN);
      lvl_q  <= ~lvl_q;
    end else if (left_q != '0) begin
      left_q <= left_q - PW'(1);
    end
  end

  assign pin_o = toggle_i ? lvl_q : (left_q != '0);
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog #(
  parameter int unsigned    CW    = 32,
  parameter logic [CW-1:0]  KEY_A = CW'(16'h5EED),
  parameter logic [CW-1:0]  KEY_B = CW'(16'hC0DE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          key_we_i,
  input  logic [CW-1:0] key_i,
  input  logic          zero_i,
  output logic          service_o,
  output logic          expired_o
);
  logic armed_q, expired_q;

  assign service_o = active_i && key_we_i && armed_q && (key_i == KEY_B) && !expired_q;
  assign expired_o = expired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      expired_q <= 1'b0;
    end else begin
      // any key write other than the first key disarms
      if (key_we_i) armed_q <= active_i && (key_i == KEY_A);
      if (active_i && zero_i) expired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr64_split.sv
module tmr64_split
  import tmr64_pkg::*;
#(
  parameter int unsigned   CW        = 32,
  parameter int unsigned   PULSE_LEN = 12,
  parameter logic [CW-1:0] KEY_A     = CW'(16'h5EED),
  parameter logic [CW-1:0] KEY_B     = CW'(16'hC0DE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  input  logic          tin_lo_i,
  input  logic          tin_hi_i,
  output logic          tout_lo_o,
  output logic          tout_hi_o,
  output logic          irq_lo_o,
  output logic          irq_hi_o,
  output logic          wd_o
);
  localparam int unsigned TW = 2 * CW;

  tmr_mode_e     mode_q;
  half_cfg_t     cfg_lo_q, cfg_hi_q;
  logic [CW-1:0] prd_lo_q, prd_hi_q, cnt_lo_q, cnt_hi_q, cnt_lo_d, cnt_hi_d;
  logic          irq_lo_q, irq_hi_q;
  logic [1:0]    pin_in, pin_rise, pin_hit, pin_tgl, pin_out;

  logic wr_ctrl, wr_prd_lo, wr_prd_hi, wr_cnt_lo, wr_cnt_hi, wr_key;
  logic wd_mode, chain, split, enter_wd, wd_service, cnt_zero;
  logic tick_lo, tick_hi, inc_lo, inc_hi, match_lo, match_hi;

  assign wr_ctrl   = we_i && (addr_i == A_CTRL);
  assign wr_prd_lo = we_i && (addr_i == A_PRD_LO);
  assign wr_prd_hi = we_i && (addr_i == A_PRD_HI);
  assign wr_cnt_lo = we_i && (addr_i == A_CNT_LO);
  assign wr_cnt_hi = we_i && (addr_i == A_CNT_HI);
  assign wr_key    = we_i && (addr_i == A_WD_KEY);

  assign wd_mode  = (mode_q == M_WDOG);
  assign chain    = (mode_q == M_CHAIN);
  assign split    = (mode_q == M_SPLIT);
  assign enter_wd = wr_ctrl && !wd_mode && (wdata_i[1:0] == 2'd2);
  assign cnt_zero = ({cnt_hi_q, cnt_lo_q} == '0);

  // input conditioning, one lane per half
  assign pin_in = {tin_hi_i, tin_lo_i};
  for (genvar g = 0; g < 2; g++) begin : g_sync
    tmr_in_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_in[g]),
      .rise_o (pin_rise[g])
    );
  end

  assign tick_lo  = cfg_lo_q.ext ? pin_rise[0] : 1'b1;
  assign tick_hi  = cfg_hi_q.ext ? pin_rise[1] : 1'b1;
  assign inc_lo   = cfg_lo_q.en && tick_lo && !wd_mode;
  assign inc_hi   = cfg_hi_q.en && tick_hi && split;
  assign match_lo = inc_lo && (cnt_lo_q == prd_lo_q) && (!chain || (cnt_hi_q == prd_hi_q));
  assign match_hi = inc_hi && (cnt_hi_q == prd_hi_q);

  tmr_wdog #(.CW(CW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (wd_mode),
    .key_we_i  (wr_key),
    .key_i     (wdata_i),
    .zero_i    (cnt_zero),
    .service_o (wd_service),
    .expired_o (wd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= M_CHAIN;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      prd_lo_q <= '0;
      prd_hi_q <= '0;
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        if (!wd_mode && (wdata_i[1:0] != 2'd3)) mode_q <= tmr_mode_e'(wdata_i[1:0]);
        cfg_lo_q <= half_cfg_t'(wdata_i[5:2]);
        cfg_hi_q <= half_cfg_t'(wdata_i[9:6]);
      end
      // one-shot stop wins over a concurrent control write
      if (match_lo && cfg_lo_q.oneshot) cfg_lo_q.en <= 1'b0;
      if (match_hi && cfg_hi_q.oneshot) cfg_hi_q.en <= 1'b0;
      if (wr_prd_lo) prd_lo_q <= wdata_i;
      if (wr_prd_hi) prd_hi_q <= wdata_i;
      irq_lo_q <= match_lo;
      irq_hi_q <= match_hi;
    end
  end

  always_comb begin
    cnt_lo_d = cnt_lo_q;
    cnt_hi_d = cnt_hi_q;
    if (enter_wd) begin
      {cnt_hi_d, cnt_lo_d} = {prd_hi_q, prd_lo_q};
    end else if (wd_mode) begin
      if (wd_service)     {cnt_hi_d, cnt_lo_d} = {prd_hi_q, prd_lo_q};
      else if (!cnt_zero) {cnt_hi_d, cnt_lo_d} = {cnt_hi_q, cnt_lo_q} - TW'(1);
    end else begin
      if (wr_cnt_lo)     cnt_lo_d = wdata_i;
      else if (match_lo) cnt_lo_d = '0;
      else if (inc_lo)   cnt_lo_d = cnt_lo_q + CW'(1);

      if (wr_cnt_hi) cnt_hi_d = wdata_i;
      else if (chain) begin
        if (match_lo)                    cnt_hi_d = '0;
        else if (inc_lo && &cnt_lo_q)    cnt_hi_d = cnt_hi_q + CW'(1);
      end else begin
        if (match_hi)    cnt_hi_d = '0;
        else if (inc_hi) cnt_hi_d = cnt_hi_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
    end else begin
      cnt_lo_q <= cnt_lo_d;
      cnt_hi_q <= cnt_hi_d;
    end
  end

  assign pin_hit = {match_hi, match_lo};
  assign pin_tgl = {cfg_hi_q.toggle, cfg_lo_q.toggle};
  for (genvar g = 0; g < 2; g++) begin : g_pin
    tmr_pin_out #(.PULSE_LEN(PULSE_LEN)) u_pin (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (pin_hit[g]),
      .toggle_i (pin_tgl[g]),
      .pin_o    (pin_out[g])
    );
  end

  assign tout_lo_o = pin_out[0];
  assign tout_hi_o = pin_out[1];
  assign irq_lo_o  = irq_lo_q;
  assign irq_hi_o  = irq_hi_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[1:0] = mode_q;
        rdata_o[5:2] = cfg_lo_q;
        rdata_o[9:6] = cfg_hi_q;
      end
      A_PRD_LO: rdata_o = prd_lo_q;
      A_PRD_HI: rdata_o = prd_hi_q;
      A_CNT_LO: rdata_o = cnt_lo_q;
      A_CNT_HI: rdata_o = cnt_hi_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr64_split_chk.sv
module tmr64_split_chk #(
  parameter int unsigned TW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode,
  input logic [TW-1:0] cnt,
  input logic          wd_o,
  input logic          irq_lo_o,
  input logic          irq_hi_o,
  input logic          tout_lo_o,
  input logic          toggle_lo,
  input logic          oneshot_lo,
  input logic          en_lo
);
  // R12
  wd_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_o |=> wd_o);

  // R11
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'd2) |=> (mode == 2'd2));

  // R12
  wd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == 2'd2) && (cnt == '0)) |=> wd_o);

  // R6
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lo_o && $past(oneshot_lo)) |-> !en_lo);

  // R4
  chain_hi_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'd0) |=> !irq_hi_o);

  // R7
  pulse_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tout_lo_o) && !toggle_lo && $stable(toggle_lo)) |=> tout_lo_o);
endmodule

bind tmr64_split tmr64_split_chk #(.TW(2 * CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode       (mode_q),
  .cnt        ({cnt_hi_q, cnt_lo_q}),
  .wd_o       (wd_o),
  .irq_lo_o   (irq_lo_o),
  .irq_hi_o   (irq_hi_o),
  .tout_lo_o  (tout_lo_o),
  .toggle_lo  (cfg_lo_q.toggle),
  .oneshot_lo (cfg_lo_q.oneshot),
  .en_lo      (cfg_lo_q.en)
);

// File: tb/tmr64_split_bench.sv
`timescale 1ns/1ps
module tmr64_split_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tin_lo_i = 1'b0, tin_hi_i = 1'b0;
  logic        tout_lo_o, tout_hi_o, irq_lo_o, irq_hi_o, wd_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  tmr64_split u_tmr64_split (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .tin_lo_i, .tin_hi_i, .tout_lo_o, .tout_hi_o,
    .irq_lo_o, .irq_hi_o, .wd_o
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic wait_irq(input bit hi, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk_i);
      seen = hi ? irq_hi_o : irq_lo_o;
    end
  endtask

  task automatic interval(input bit hi, output int n);
    bit seen;
    wait_irq(hi, seen);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!(hi ? irq_hi_o : irq_lo_o) && n < 300);
  endtask

  task automatic pulses(input bit hi, input int n);
    for (int i = 0; i < n; i++) begin
      repeat (12) begin @(negedge clk_i); if (hi) tin_hi_i = 1'b1; else tin_lo_i = 1'b1; end
      repeat (12) begin @(negedge clk_i); if (hi) tin_hi_i = 1'b0; else tin_lo_i = 1'b0; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL all-requirements watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, c1, c2, c3;
    int n, cnt;
    bit seen, lvl, hi_seen;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check(d == 0, "R1 reset register", d, 0);
    end
    check({tout_lo_o, tout_hi_o, irq_lo_o, irq_hi_o, wd_o} == 0, "R1 reset outputs",
          {tout_lo_o, tout_hi_o, irq_lo_o, irq_hi_o, wd_o}, 0);

    // R2 split periods, halves with different periods
    for (int p = 1; p <= 6; p++) begin
      wr(0, 32'h1); wr(3, 0); wr(4, 0); wr(1, p); wr(2, 7 - p);
      wr(0, 32'h45);
      interval(1'b0, n);
      check(n == p + 1, "R2 low interval", n, p + 1);
      interval(1'b1, n);
      check(n == 8 - p, "R2 high interval", n, 8 - p);
    end

    // R3 external edge counting per pin
    wr(1, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
    for (int k = 0; k <= 4; k++) begin
      wr(0, 32'h1); wr(3, 0); wr(4, 0);
      wr(0, 32'hCD);
      pulses(1'b0, k);
      pulses(1'b1, k + 2);
      repeat (6) @(negedge clk_i);
      rd(3, d);
      check(d == k, "R3 low edge count", d, k);
      rd(4, d);
      check(d == k + 2, "R3 high edge count", d, k + 2);
    end

    // R4 chained carry
    wr(0, 32'h0); wr(3, 32'hFFFF_FFFC); wr(4, 0);
    wr(0, 32'h4);
    repeat (10) @(negedge clk_i);
    wr(0, 32'h0);
    rd(4, d);
    check(d == 1, "R4 carry into high", d, 1);
    rd(3, d);
    check(d < 16, "R4 low after wrap", d, 8);

    // R4 64-bit match
    wr(3, 32'hFFFF_FFFE); wr(4, 0); wr(1, 1); wr(2, 1);
    @(negedge clk_i); we_i = 1'b1; addr_i = 0; wdata_i = 32'h4;
    @(negedge clk_i); we_i = 1'b0;
    seen = 1'b0; hi_seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (irq_lo_o) seen = 1'b1;
      if (irq_hi_o) hi_seen = 1'b1;
    end
    check(seen, "R4 chained match event", seen, 1);
    check(!hi_seen, "R4 high event quiet", hi_seen, 0);
    wr(0, 32'h0);

    // R5 split: no carry
    wr(0, 32'h1); wr(3, 32'hFFFF_FFFC); wr(4, 0); wr(1, 32'hFFFF_FFFF);
    wr(0, 32'h5);
    repeat (10) @(negedge clk_i);
    wr(0, 32'h1);
    rd(4, d);
    check(d == 0, "R5 high untouched", d, 0);

    // R6 one-shot
    wr(3, 0); wr(1, 3);
    wr(0, 32'h15);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (irq_lo_o) cnt++;
    end
    check(cnt == 1, "R6 one event", cnt, 1);
    rd(0, d);
    check(d[9:0] == 10'h11, "R6 enable cleared", d[9:0], 10'h11);

    // R7 pulse width
    wr(3, 0); wr(1, 30);
    wr(0, 32'h5);
    wait_irq(1'b0, seen);
    check(tout_lo_o == 1'b1, "R7 pin rises with event", tout_lo_o, 1);
    n = 0;
    while (tout_lo_o && n < 100) begin
      n++;
      @(negedge clk_i);
    end
    check(n == 12, "R7 pulse width", n, 12);

    // R8 toggle
    wr(0, 32'h1); wr(3, 0); wr(1, 5);
    wr(0, 32'h25);
    wait_irq(1'b0, seen);
    lvl = tout_lo_o;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      wait_irq(1'b0, seen);
      check(tout_lo_o == !lvl, "R8 level flips", tout_lo_o, !lvl);
      lvl = tout_lo_o;
    end
    wr(0, 32'h1);

    // R9 watchdog entry and countdown
    wr(1, 40); wr(2, 0);
    wr(0, 32'h2);
    check(wd_o == 1'b0, "R12 not yet expired", wd_o, 0);
    repeat (10) @(negedge clk_i);
    rd(3, c1);
    check(c1 > 20 && c1 < 40, "R9 counting down", c1, 29);
    rd(4, d);
    check(d == 0, "R9 high count loaded", d, 0);

    // R10 service sequence
    wr(5, 32'h5EED); wr(5, 32'hC0DE);
    rd(3, c1);
    check(c1 >= 36 && c1 <= 40, "R10 reload on key pair", c1, 39);
    repeat (5) @(negedge clk_i);
    rd(3, c1);
    wr(5, 32'hC0DE); wr(5, 32'h5EED);
    rd(3, c2);
    check(c2 < c1, "R10 wrong order no reload", c2, c1 - 5);
    wr(5, 32'h1234); wr(5, 32'hC0DE);
    rd(3, c3);
    check(c3 < c2, "R10 wrong key no reload", c3, c2 - 5);
    wr(3, 1000);
    rd(3, d);
    check(d < c3, "R10 count write ignored", d, c3 - 3);

    // R11 mode lock
    wr(0, 32'h0);
    rd(0, d);
    check(d[1:0] == 2'd2, "R11 mode locked", d[1:0], 2);

    // R12 expiry
    repeat (60) @(negedge clk_i);
    check(wd_o == 1'b1, "R12 expired", wd_o, 1);
    wr(5, 32'h5EED); wr(5, 32'hC0DE);
    repeat (2) @(negedge clk_i);
    check(wd_o == 1'b1, "R12 stays asserted", wd_o, 1);
    rd(3, d);
    check(d == 0, "R12 late service ignored", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule